// File: doc/BRIEF.md
# Reset and Power-Down Sequencer

This block supervises an active-low reset/power-down pin sampled in the system clock domain. It moves the device through four phases: ready, a pending check on a fresh low level, power-down and recovery. The pin's state drives the device's write gating, its output-buffer gating and a clean-up pulse for neighbouring logic. A low level counts as a real reset only after it has been held for a programmable number of cycles. Shorter dips leave every output untouched.

Once a reset qualifies, both ready flags drop, writes are blocked and the data outputs are forced to high impedance. A one-cycle clean-up pulse tells the command interface and the status register to clear and the read path to return to asynchronous random read. If a program or erase is running at that moment, an abort request goes to its controller. The request stays up until the controller acknowledges it. An error flag records an acknowledgement that misses its deadline.

When the pin returns high, read access and write access are each released after their own programmable delay. A new low level during recovery restarts that wait.

Top module: `rpd_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it, `read_ready` and `write_ready` are 0, `write_inhibit` and `force_hiz` are 1, and `status_clr`, `abort_req` and `abort_err` are 0. The block therefore starts in power-down.
- R2: When the device is ready, a run of fewer than MIN_LOW consecutive low samples of `rp_n` is ignored. The ready flags stay 1, `write_inhibit` and `force_hiz` stay 0 and no `status_clr` pulse occurs. The run length counts only consecutive lows, so a single high sample restarts it.
- R3: When `rp_n` is sampled low on MIN_LOW consecutive edges starting from the ready state, the next cycle shows `read_ready`=0, `write_ready`=0, `write_inhibit`=1 and `force_hiz`=1. These values hold while `rp_n` stays low.
- R4: Each qualified reset gives exactly one `status_clr` pulse, one cycle long, in the cycle after the MIN_LOW-th low edge. This pulse is the request to clear the status and command logic and to restore asynchronous random read mode.
- R5: After power-down, `read_ready` rises and `force_hiz` falls READ_DLY cycles after the first edge that samples `rp_n` high.
- R6: After power-down, `write_ready` rises and `write_inhibit` falls WRITE_DLY cycles after the first edge that samples `rp_n` high.
- R7: A single low sample of `rp_n` during recovery clears any ready flag already raised, in the next cycle. Both delays then count again from the next high sample.
- R8: If `op_busy` is 1 at the edge that qualifies a reset, `abort_req` rises together with the `status_clr` pulse. It stays 1 until an edge samples `abort_ack` high, and falls in the next cycle. If `op_busy` is 0, `abort_req` stays 0.
- R9: `abort_err` becomes 1 when `abort_ack` is not sampled high on any of the first ABORT_LIM edges after `abort_req` rises. It is sticky, and it clears only on `rst` or when a new abort starts.
- R10: `abort_ack` has no effect while no abort is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rp_n | input | 1 | Reset/power-down pin, active low, already synchronised |
| op_busy | input | 1 | Program or erase in progress |
| abort_ack | input | 1 | Program/erase controller confirms the abort |
| write_inhibit | output | 1 | Writes blocked |
| status_clr | output | 1 | One-cycle clean-up pulse on a qualified reset |
| abort_req | output | 1 | Abort request to the program/erase controller |
| abort_err | output | 1 | Abort not acknowledged within ABORT_LIM cycles |
| force_hiz | output | 1 | Data outputs forced to high impedance |
| read_ready | output | 1 | Read access allowed |
| write_ready | output | 1 | Write access allowed |

## Verification
Every result comes from a register, so each result is due on the edge after its cause. `status_clr` and `abort_req` appear one cycle after the MIN_LOW-th low edge. The ready flags rise READ_DLY and WRITE_DLY edges after the first high edge, which the bench sees at its (delay+1)-th falling-edge sample after release. `abort_err` is set on the ABORT_LIM-th unacknowledged edge. The bench drives and samples only on falling edges. It counts samples from the falling edge where it changed the stimulus and compares those counts with figures derived from the small parameter set. It sweeps pulse lengths from 1 to MIN_LOW+3 and acknowledgement delays from 0 to ABORT_LIM+1.

// File: rtl/rpd_pkg.sv
package rpd_pkg;

    // Sequencer phases
    typedef enum logic [1:0] {
        ST_READY  = 2'd0,   // both accesses allowed
        ST_GLITCH = 2'd1,   // pin low, not yet qualified
        ST_DOWN   = 2'd2,   // qualified reset held
        ST_RECOV  = 2'd3    // pin released, delays running
    } rpd_state_e;

    // Index of each access delay in the recovery vector
    localparam int unsigned ACC_RD = 0;
    localparam int unsigned ACC_WR = 1;
    localparam int unsigned ACC_N  = 2;

    // Bits for a counter that runs 0 .. lim-1
    function automatic int unsigned cnt_bits(input int unsigned lim);
        return (lim < 2) ? 1 : $clog2(lim);
    endfunction

endpackage

// File: rtl/rpd_hold_cnt.sv
// Counts qualifying steps; hit marks the LIMIT-th consecutive step.
module rpd_hold_cnt #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    output logic hit
);
    localparam int unsigned W = rpd_pkg::cnt_bits(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    assign hit = step && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (step && !hit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rpd_abort.sv
// Abort handshake toward the program/erase controller with a deadline.
module rpd_abort #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic ack,
    output logic req,
    output logic err
);
    logic req_q, err_q, win_hit;

    rpd_hold_cnt #(.LIMIT(LIMIT)) u_window (
        .clk   (clk),
        .rst   (rst),
        .clear (!req_q || start),
        .step  (req_q && !ack && !err_q),
        .hit   (win_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            err_q <= 1'b0;
        end else if (start) begin
            req_q <= 1'b1;
            err_q <= 1'b0;
        end else begin
            if (ack) req_q <= 1'b0;
            if (win_hit) err_q <= 1'b1;
        end
    end

    assign req = req_q;
    assign err = err_q;
endmodule

// File: rtl/rpd_seq.sv
module rpd_seq #(
    parameter int unsigned MIN_LOW   = 32,
    parameter int unsigned READ_DLY  = 50,
    parameter int unsigned WRITE_DLY = 25,
    parameter int unsigned ABORT_LIM = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic rp_n,
    input  logic op_busy,
    input  logic abort_ack,
    output logic write_inhibit,
    output logic status_clr,
    output logic abort_req,
    output logic abort_err,
    output logic force_hiz,
    output logic read_ready,
    output logic write_ready
);
    import rpd_pkg::*;

    rpd_state_e state_q, state_d;
    logic [ACC_N-1:0] rdy_q, rdy_d, dly_hit;
    logic clr_q;
    logic watching, in_recov;
    logic low_step, low_hit;

    assign watching = (state_q == ST_READY) || (state_q == ST_GLITCH);
    assign in_recov = (state_q == ST_RECOV);
    assign low_step = watching && !rp_n;

    // Minimum low-hold qualifier
    rpd_hold_cnt #(.LIMIT(MIN_LOW)) u_lowq (
        .clk   (clk),
        .rst   (rst),
        .clear (!low_step),
        .step  (low_step),
        .hit   (low_hit)
    );

    // Separate read and write recovery delays
    for (genvar g = 0; g < ACC_N; g++) begin : g_dly
        rpd_hold_cnt #(.LIMIT((g == ACC_RD) ? READ_DLY : WRITE_DLY)) u_dly (
            .clk   (clk),
            .rst   (rst),
            .clear (!in_recov),
            .step  (in_recov && rp_n && !rdy_q[g]),
            .hit   (dly_hit[g])
        );
    end

    assign rdy_d = rdy_q | dly_hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY, ST_GLITCH: begin
                if (rp_n)         state_d = ST_READY;
                else if (low_hit) state_d = ST_DOWN;
                else              state_d = ST_GLITCH;
            end
            ST_DOWN: begin
                if (rp_n) state_d = ST_RECOV;
            end
            ST_RECOV: begin
                if (!rp_n)       state_d = ST_DOWN;
                else if (&rdy_d) state_d = ST_READY;
            end
            default: state_d = ST_DOWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_DOWN;
            rdy_q   <= '0;
            clr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            rdy_q   <= (state_d == ST_DOWN) ? '0 : rdy_d;
            clr_q   <= low_hit;
        end
    end

    // Abort toward an in-progress program or erase
    rpd_abort #(.LIMIT(ABORT_LIM)) u_abort (
        .clk   (clk),
        .rst   (rst),
        .start (low_hit && op_busy),
        .ack   (abort_ack),
        .req   (abort_req),
        .err   (abort_err)
    );

    assign status_clr    = clr_q;
    assign read_ready    = rdy_q[ACC_RD];
    assign write_ready   = rdy_q[ACC_WR];
    assign force_hiz     = !rdy_q[ACC_RD];
    assign write_inhibit = !rdy_q[ACC_WR];
endmodule

// File: rtl/rpd_seq_chk.sv
module rpd_seq_chk (
    input logic clk,
    input logic rst,
    input logic rp_n,
    input logic abort_ack,
    input logic status_clr,
    input logic abort_req,
    input logic abort_err,
    input logic read_ready,
    input logic write_ready
);
    p_clr_single_r4: assert property (@(posedge clk) disable iff (rst)
        status_clr |=> !status_clr);

    p_flags_down_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(status_clr) |-> (!read_ready && !write_ready));

    p_rd_release_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(read_ready) |-> $past(rp_n));

    p_wr_release_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(write_ready) |-> $past(rp_n));

    p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (abort_req && !abort_ack) |=> abort_req);

    p_req_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (abort_req && abort_ack) |=> (!abort_req || status_clr));

    p_err_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(abort_err) |-> $past(abort_req));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        abort_err |=> (abort_err || status_clr));
endmodule

bind rpd_seq rpd_seq_chk u_rpd_seq_chk (
    .clk         (clk),
    .rst         (rst),
    .rp_n        (rp_n),
    .abort_ack   (abort_ack),
    .status_clr  (status_clr),
    .abort_req   (abort_req),
    .abort_err   (abort_err),
    .read_ready  (read_ready),
    .write_ready (write_ready)
);

// File: tb/rpd_seq_bench.sv
module rpd_seq_bench;
    localparam int MINL = 3;
    localparam int RD   = 4;
    localparam int WR   = 6;
    localparam int AL   = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rp_n = 1'b1;
    logic op_busy = 1'b0;
    logic abort_ack = 1'b0;
    logic write_inhibit, status_clr, abort_req, abort_err;
    logic force_hiz, read_ready, write_ready;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rpd_seq #(
        .MIN_LOW(MINL), .READ_DLY(RD), .WRITE_DLY(WR), .ABORT_LIM(AL)
    ) u_rpd_seq (
        .clk(clk), .rst(rst), .rp_n(rp_n), .op_busy(op_busy),
        .abort_ack(abort_ack), .write_inhibit(write_inhibit),
        .status_clr(status_clr), .abort_req(abort_req),
        .abort_err(abort_err), .force_hiz(force_hiz),
        .read_ready(read_ready), .write_ready(write_ready)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Hold rp_n low for len samples; report clean-up pulses, the sample
    // index of the first pulse and whether the outputs stayed in ready form.
    task automatic low_pulse(input int len, output int n_clr, output int clr_at,
                             output int kept);
        rp_n = 1'b0;
        n_clr = 0; clr_at = -1; kept = 1;
        for (int i = 1; i <= len; i++) begin
            tick();
            if (status_clr) begin
                n_clr++;
                if (clr_at < 0) clr_at = i;
            end
            if (!read_ready || !write_ready || force_hiz || write_inhibit) kept = 0;
        end
    endtask

    // Release rp_n and find the sample at which each access opens.
    task automatic release_measure(input string tag, output int t_rd, output int t_wr);
        rp_n = 1'b1;
        t_rd = -1; t_wr = -1;
        for (int j = 1; j <= 20; j++) begin
            tick();
            if (t_rd < 0 && read_ready) t_rd = j;
            if (t_wr < 0 && write_ready) t_wr = j;
            check_eq({tag, " R5 hiz tracks read access"}, int'(force_hiz), int'(!read_ready));
            check_eq({tag, " R6 inhibit tracks write access"}, int'(write_inhibit), int'(!write_ready));
        end
    endtask

    initial begin
        int n_clr, clr_at, kept, t_rd, t_wr;
        tick();
        tick();
        // R1: reset state
        check_eq("R1 read_ready", int'(read_ready), 0);
        check_eq("R1 write_ready", int'(write_ready), 0);
        check_eq("R1 force_hiz", int'(force_hiz), 1);
        check_eq("R1 write_inhibit", int'(write_inhibit), 1);
        check_eq("R1 status_clr", int'(status_clr), 0);
        check_eq("R1 abort_req", int'(abort_req), 0);
        check_eq("R1 abort_err", int'(abort_err), 0);
        rst = 1'b0;
        release_measure("power-up", t_rd, t_wr);
        check_eq("R5 power-up read delay", t_rd, RD + 1);
        check_eq("R6 power-up write delay", t_wr, WR + 1);

        // Pulse-length sweep
        for (int len = 1; len <= MINL + 3; len++) begin
            low_pulse(len, n_clr, clr_at, kept);
            if (len < MINL) begin
                check_eq("R2 no clean-up pulse", n_clr, 0);
                check_eq("R2 outputs kept", kept, 1);
                release_measure("glitch", t_rd, t_wr);
                check_eq("R2 read still open", t_rd, 1);
                check_eq("R2 write still open", t_wr, 1);
            end else begin
                check_eq("R4 one clean-up pulse", n_clr, 1);
                check_eq("R4 pulse position", clr_at, MINL);
                check_eq("R3 read_ready low", int'(read_ready), 0);
                check_eq("R3 write_ready low", int'(write_ready), 0);
                check_eq("R3 force_hiz", int'(force_hiz), 1);
                check_eq("R3 write_inhibit", int'(write_inhibit), 1);
                release_measure("valid", t_rd, t_wr);
                check_eq("R5 read delay", t_rd, RD + 1);
                check_eq("R6 write delay", t_wr, WR + 1);
            end
        end

        // R2: two short runs split by one high sample do not add up
        low_pulse(MINL - 1, n_clr, clr_at, kept);
        rp_n = 1'b1;
        tick();
        low_pulse(MINL - 1, n_clr, clr_at, kept);
        check_eq("R2 split runs ignored", n_clr, 0);
        check_eq("R2 split runs keep outputs", kept, 1);
        release_measure("split", t_rd, t_wr);

        // R7: low during recovery, after read opened but before write
        low_pulse(MINL, n_clr, clr_at, kept);
        rp_n = 1'b1;
        for (int j = 1; j <= RD + 1; j++) tick();
        check_eq("R7 read opened first", int'(read_ready), 1);
        check_eq("R7 write still closed", int'(write_ready), 0);
        rp_n = 1'b0;
        tick();
        check_eq("R7 read closed again", int'(read_ready), 0);
        check_eq("R7 no new clean-up pulse", int'(status_clr), 0);
        release_measure("restart", t_rd, t_wr);
        check_eq("R7 read delay restarted", t_rd, RD + 1);
        check_eq("R7 write delay restarted", t_wr, WR + 1);

        // R8 / R9: acknowledgement delay sweep
        for (int d = 0; d <= AL + 1; d++) begin
            op_busy = 1'b1;
            low_pulse(MINL, n_clr, clr_at, kept);
            op_busy = 1'b0;
            check_eq("R8 abort raised with pulse", int'(abort_req), 1);
            check_eq("R9 error cleared by new abort", int'(abort_err), 0);
            for (int k = 0; k < d; k++) tick();
            check_eq("R8 abort held until ack", int'(abort_req), 1);
            abort_ack = 1'b1;
            tick();
            abort_ack = 1'b0;
            check_eq("R8 abort dropped after ack", int'(abort_req), 0);
            check_eq("R9 deadline error", int'(abort_err), (d >= AL) ? 1 : 0);
            release_measure("abort", t_rd, t_wr);
            check_eq("R9 error sticky", int'(abort_err), (d >= AL) ? 1 : 0);
        end

        // R8: idle controller gets no abort
        low_pulse(MINL, n_clr, clr_at, kept);
        check_eq("R8 no abort when idle", int'(abort_req), 0);
        release_measure("idle", t_rd, t_wr);

        // R10: stray acknowledgement while ready
        abort_ack = 1'b1;
        for (int j = 0; j < 3; j++) tick();
        abort_ack = 1'b0;
        tick();
        check_eq("R10 abort_req unaffected", int'(abort_req), 0);
        check_eq("R10 abort_err unaffected", int'(abort_err), 1);
        check_eq("R10 read_ready unaffected", int'(read_ready), 1);
        check_eq("R10 write_ready unaffected", int'(write_ready), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule